// File: doc/BRIEF.md
# GPIO Bank Register File with Masked-Write Aliases

This block holds the pin control state for one bank of general-purpose pins. The pins are grouped into ports of `PORT_W` bits, four ports by default, which gives 32 pins. Each port has three writable registers and one read-only register, all reached over a simple single-cycle 32-bit read/write bus. The writable registers are a mode select that hands the pin to the GPIO function, a drive enable and a drive level. The read-only register returns the synchronized pin levels.

Every writable register can also be reached at a second, aliased address. A write there carries a per-bit enable byte next to the data byte. Only the enabled pins take the new value, so software can change single pins without a read-modify-write sequence, and two agents working on different pins of the same port cannot undo each other's writes. Reads are registered and return their data one cycle after the request. The pin-facing outputs are registered and follow the register contents one cycle later.

Top module: `gpio_bank_regs`

## Requirements
- R1: While `rst` is high, every register resets to zero, and `pin_sel`, `pin_oe`, `pin_out` and `bus_rdata` are all zero one cycle later. Every pin is then an undriven input.
- R2: Address decode works as follows. Byte address bits [3:2] select the port. Bits [6:4] select the register: 0 is mode select, 1 is drive enable, 2 is drive level and 3 is pin input. Bits [10:7] must be zero. Bit 11 selects the masked alias. Register data sits in bits [7:0], and bits [31:8] read as zero.
- R3: A plain write (bit 11 = 0) to a writable register replaces all eight bits with `bus_wdata[7:0]`. `bus_wdata[31:8]` has no effect.
- R4: A masked write (bit 11 = 1) treats `bus_wdata[15:8]` as a per-bit enable. Only bits whose enable is 1 take the value in `bus_wdata[7:0]`, and all other bits keep their value. An all-zero enable changes nothing.
- R5: A read at a masked-alias address returns the same value as a read at the matching plain address.
- R6: Bit b of port p appears on output index p*8+b of `pin_sel`, `pin_oe` and `pin_out`. Each output follows its register one clock after the register changes.
- R7: `pin_out` for a pin is the drive-level bit when that pin's drive-enable bit is 1, and 0 otherwise. The stored drive level is kept while the enable is 0.
- R8: `pin_in` passes through two synchronizing flops. A level present at clock edge k can be read by a read accepted at edge k+2 or later. A read accepted at edge k+1 returns the earlier level.
- R9: Writes to the input register, to register selects 4 to 7, or to addresses with bits [10:7] nonzero change no register. Reads of selects 4 to 7 or of addresses with bits [10:7] nonzero return zero.
- R10: When a read and a write hit the same register in the same cycle, the read returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | ADDR_W (12) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data; bits [15:8] are the enable byte on masked writes |
| bus_rdata | output | DATA_W (32) | Read data, valid the cycle after `bus_rd`, held otherwise |
| pin_in | input | NUM_PORTS*PORT_W (32) | Asynchronous pin levels |
| pin_sel | output | NUM_PORTS*PORT_W (32) | Per-pin GPIO mode select |
| pin_oe | output | NUM_PORTS*PORT_W (32) | Per-pin drive enable |
| pin_out | output | NUM_PORTS*PORT_W (32) | Per-pin drive level, gated by drive enable |

## Verification
The masked write is the main target. The bench uses enable bytes that mix set and cleared enables, so that a design merging the wrong byte, or writing the whole port, shows a changed bit that should have been kept. An all-zero enable is also tested, because it must be a no-op. Aliased reads are compared with plain reads, which catches a decoder that returns zero or a different register at the alias. The synchronizer latency is checked at the exact cycle: one stage too few makes the new level visible a cycle early, and one too many hides it at the expected read. Writes to the input register, to unused selects and to another bank's address are tested, because a decoder that ignores bits [10:7] or bit 6 corrupts a live register. A read that coincides with a write to the same register must return the old value. Finally, a pin with drive enable cleared must not drive even when its stored level is 1.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  // address field positions (byte address)
  localparam int PORT_LSB  = 2;
  localparam int PORT_FW   = 2;
  localparam int SEL_LSB   = 4;
  localparam int SEL_W     = 3;
  localparam int BANK_LSB  = 7;
  localparam int ALIAS_BIT = 11;
  localparam int NUM_WR_REGS = 3;

  typedef enum logic [SEL_W-1:0] {
    RS_CFG = 3'd0,
    RS_OE  = 3'd1,
    RS_OUT = 3'd2,
    RS_IN  = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_addr_decode.sv
`timescale 1ns/1ps
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_PORTS = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [PORT_FW-1:0] port,
  output logic [SEL_W-1:0]   sel,
  output logic               alias_m,
  output logic               wr_ok,
  output logic               rd_ok
);
  logic in_bank;

  assign port    = addr[PORT_LSB +: PORT_FW];
  assign sel     = addr[SEL_LSB +: SEL_W];
  assign alias_m = addr[ALIAS_BIT];
  assign in_bank = (addr[ALIAS_BIT-1:BANK_LSB] == '0) && (int'(port) < NUM_PORTS);
  assign wr_ok   = in_bank && (int'(sel) < NUM_WR_REGS);
  assign rd_ok   = in_bank && (sel <= RS_IN);
endmodule

// File: rtl/gpio_port_reg.sv
`timescale 1ns/1ps
module gpio_port_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_plain,
  input  logic         wr_mask,
  input  logic [W-1:0] wval,
  input  logic [W-1:0] wen,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (wr_plain) q <= wval;
    else if (wr_mask)  q <= (q & ~wen) | (wval & wen);
  end

  // R3
  plain_wr_chk: assert property (@(posedge clk) disable iff (rst)
    wr_plain |=> (q == $past(wval)));

  // R4
  mask_keep_chk: assert property (@(posedge clk) disable iff (rst)
    wr_mask |=> (((q ^ $past(q)) & ~$past(wen)) == '0));
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  logic [N-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd2) warm <= warm + 2'd1;
  end

  // R8
  sync_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_bank_regs.sv
`timescale 1ns/1ps
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  output logic [DATA_W-1:0]             bus_rdata,
  input  logic [NUM_PORTS*PORT_W-1:0]   pin_in,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_sel,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_oe,
  output logic [NUM_PORTS*PORT_W-1:0]   pin_out
);
  localparam int PINS  = NUM_PORTS * PORT_W;
  localparam int FLATW = NUM_WR_REGS * PINS;

  logic [PORT_FW-1:0] port;
  logic [SEL_W-1:0]   sel;
  logic               alias_m, wr_ok, rd_ok;

  gpio_addr_decode #(.ADDR_W(ADDR_W), .NUM_PORTS(NUM_PORTS)) u_dec (
    .addr(bus_addr), .port(port), .sel(sel),
    .alias_m(alias_m), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  logic [PORT_W-1:0] regq [NUM_WR_REGS][NUM_PORTS];
  logic [FLATW-1:0]  reg_flat;

  for (genvar r = 0; r < NUM_WR_REGS; r++) begin : g_kind
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic hit_here;
      assign hit_here = bus_wr && wr_ok && (port == PORT_FW'(p)) && (sel == SEL_W'(r));
      gpio_port_reg #(.W(PORT_W)) u_reg (
        .clk(clk), .rst(rst),
        .wr_plain(hit_here && !alias_m),
        .wr_mask(hit_here && alias_m),
        .wval(bus_wdata[PORT_W-1:0]),
        .wen(bus_wdata[2*PORT_W-1:PORT_W]),
        .q(regq[r][p])
      );
      assign reg_flat[(r*NUM_PORTS+p)*PORT_W +: PORT_W] = regq[r][p];
    end
  end

  logic [PINS-1:0] in_sync;
  gpio_in_sync #(.N(PINS)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(in_sync)
  );

  // pin-facing outputs, registered
  always_ff @(posedge clk) begin
    if (rst) begin
      pin_sel <= '0;
      pin_oe  <= '0;
      pin_out <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        pin_sel[p*PORT_W +: PORT_W] <= regq[int'(RS_CFG)][p];
        pin_oe[p*PORT_W +: PORT_W]  <= regq[int'(RS_OE)][p];
        pin_out[p*PORT_W +: PORT_W] <= regq[int'(RS_OUT)][p] & regq[int'(RS_OE)][p];
      end
    end
  end

  // read path
  logic [DATA_W-1:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (rd_ok) begin
      case (sel)
        RS_CFG: rd_word[PORT_W-1:0] = regq[int'(RS_CFG)][port];
        RS_OE:  rd_word[PORT_W-1:0] = regq[int'(RS_OE)][port];
        RS_OUT: rd_word[PORT_W-1:0] = regq[int'(RS_OUT)][port];
        RS_IN:  rd_word[PORT_W-1:0] = in_sync[int'(port)*PORT_W +: PORT_W];
        default: rd_word = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_word;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (pin_sel == '0 && pin_oe == '0 && pin_out == '0 && bus_rdata == '0));

  // R9
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !wr_ok) |=> $stable(reg_flat));
endmodule

// File: tb/gpio_bank_regs_tb.sv
`timescale 1ns/1ps
module gpio_bank_regs_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_sel, pin_oe, pin_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_bank_regs u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_sel(pin_sel), .pin_oe(pin_oe), .pin_out(pin_out)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 pin_sel", pin_sel, 32'h0);
    check("R1 pin_oe", pin_oe, 32'h0);
    check("R1 pin_out", pin_out, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    rd(12'h010, d); check("R1 drive enable p0", d, 32'h0);
    rd(12'h02C, d); check("R1 drive level p3", d, 32'h0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr(12'h004, 32'hFFFF_A5C3);
    rd(12'h004, d); check("R3 upper data ignored / R2 upper zero", d, 32'h0000_00C3);
    rd(12'h000, d); check("R2 port isolation", d, 32'h0);
    wr(12'h018, 32'h0000_000F);
    wr(12'h028, 32'h0000_003C);
    settle();
    check("R6 pin_sel port1", pin_sel, 32'h0000_C300);
    check("R6 pin_oe port2", pin_oe, 32'h000F_0000);
    check("R7 pin_out gated", pin_out, 32'h000C_0000);
    rd(12'h028, d); check("R7 level kept while disabled", d, 32'h0000_003C);
  endtask

  task automatic t_masked();
    logic [31:0] d, e;
    wr(12'h020, 32'h0000_00F0);
    wr(12'h820, 32'h0000_3C0A);
    rd(12'h020, d); check("R4 masked merge", d, 32'h0000_00C8);
    wr(12'h820, 32'h0000_00FF);
    rd(12'h020, d); check("R4 zero enable no-op", d, 32'h0000_00C8);
    rd(12'h820, e); check("R5 alias read", e, d);
    wr(12'h80C, 32'h0000_8181);
    rd(12'h00C, d); check("R4 masked cfg port3", d, 32'h0000_0081);
    wr(12'h810, 32'h0000_FFFF);
    settle();
    check("R7 pin_out port0 enabled", pin_out[7:0], 32'h0000_00C8);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'hA700_0000;
    rd(12'h03C, d); check("R8 one stage not yet visible", d, 32'h0);
    rd(12'h03C, d); check("R8 visible after two stages", d, 32'h0000_00A7);
    rd(12'h83C, d); check("R5 alias input read", d, 32'h0000_00A7);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(12'h03C, 32'h0000_0000);
    wr(12'h83C, 32'h0000_FF00);
    rd(12'h03C, d); check("R9 input write ignored", d, 32'h0000_00A7);
    wr(12'h040, 32'h0000_00FF);
    rd(12'h040, d); check("R9 select 4 reads zero", d, 32'h0);
    wr(12'h0A0, 32'h0000_00FF);
    rd(12'h020, d); check("R9 other bank write ignored", d, 32'h0000_00C8);
    rd(12'h0A0, d); check("R9 other bank reads zero", d, 32'h0);
    rd(12'h070, d); check("R9 select 7 reads zero", d, 32'h0);
  endtask

  task automatic t_same_cycle();
    logic [31:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'h0000_0055;
    @(negedge clk);
    d = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R10 read returns old value", d, 32'h0);
    rd(12'h01C, d); check("R10 write landed", d, 32'h0000_0055);
  endtask

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 pins during reset", pin_oe | pin_out | pin_sel, 32'h0);
    rst = 1'b0;
    t_reset();
    t_plain();
    t_masked();
    t_input();
    t_ignored();
    t_same_cycle();
    done = 1'b1;
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_up();
    end
  end
endmodule